// File: doc/BRIEF.md
# Best-Candidate Merge and Top-Four Sorter

This block takes a fixed set of particle candidates on every clock. The default set is sixteen. Each candidate carries a valid flag, a quality rank, a position code and a tag naming the source subsystem. A particle that two or more subsystems see shows up as several candidates with the same position code but different source tags. The block folds each such group into one entry and keeps the best of them. It then ranks everything that remains and outputs the four best entries, best first.

The datapath is fully pipelined. It accepts a new candidate set on every clock and returns the matching result a fixed number of clocks later, with no stalls. A set-valid bit travels through the pipeline with its data. A downstream consumer takes the four output slots on any cycle where the output valid bit is high.

Top module: `best_cand_sorter`

## Requirements
- R1: While the synchronous active-low reset is held, and on the first cycle after it is released, `out_valid` is 0 and every output bit is 0.
- R2: Two candidates are duplicates only when all of these hold: both have the valid bit (bit 15) set, their position codes (bits 11:4) are equal, and their source tags (bits 3:2) differ. Two candidates with the same source tag are never duplicates, even when their positions match.
- R3: A candidate is removed when it has a duplicate that beats it. A duplicate beats it when its rank (bits 14:12) is higher, or when the ranks are equal and the duplicate has the lower input index. Every candidate that remains and had at least one duplicate sets the combined-source flag (output bit 0) to 1. Every other remaining candidate sets that flag to 0.
- R4: Output slot 0 (bits 15:0) holds the remaining candidate with the highest rank, slot 1 (bits 31:16) holds the next one, and so on. When two ranks are equal, the candidate with the lower input index goes first.
- R5: When fewer than four candidates remain, the remaining ones fill slots from slot 0 upward. Every unused slot is the all-zero word, so its valid bit is 0.
- R6: A filled slot carries the valid bit, rank, position and source of the chosen candidate at the same bit positions it had at the input. Bit 1 of the slot is 0. Input bits 1:0 have no effect on any output.
- R7: When a set is presented with `in_valid` = 0, the matching result has `out_valid` = 0 and all output slots are zero, whatever the candidate inputs held.
- R8: The result for a set appears exactly LATENCY clocks after that set is sampled. The default LATENCY is 10. A new set is accepted on every clock, and consecutive sets do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The candidate set on this clock is real |
| in_cands | input | NUM_IN*16 | Candidate i occupies bits [16*i+15 : 16*i] |
| out_valid | output | 1 | The result slots belong to a valid set |
| out_cands | output | NUM_OUT*16 | Slot k occupies bits [16*k+15 : 16*k], best in slot 0 |

## Verification
The bench builds the block with its default parameters: sixteen inputs, four output slots and a latency of ten. With these values every candidate index, the full three-bit rank range and the whole stage count are reachable. Random positions are drawn from only four codes and sources from three tags. This makes groups of two and three duplicates common, and it also produces same-source collisions, equal-rank ties, and sets with fewer than four survivors. Directed sets pin down the tie and exclusion cases, and runs of back-to-back random sets test the one-set-per-clock throughput.

// File: rtl/cand_pkg.sv
// Package: candidate word layout shared by the sorter and its stages.
// Assumes: a 16-bit candidate word; the field order is the external format.
package cand_pkg;

    localparam int CAND_W = 16;
    localparam int RANK_W = 3;
    localparam int POS_W  = 8;
    localparam int SRC_W  = 2;

    // Candidate word: valid, rank, position, source, spare, combined flag.
    typedef struct packed {
        logic              vld;
        logic [RANK_W-1:0] rank;
        logic [POS_W-1:0]  pos;
        logic [SRC_W-1:0]  src;
        logic              spare;
        logic              comb;
    } cand_t;

endpackage

// File: rtl/pipe_delay.sv
// Module: pipe_delay
// Delays a data word by DEPTH clocks using a chain of resettable registers.
// Assumes: DEPTH >= 0; a DEPTH of 0 is a plain wire.
module pipe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_chain
            logic [W-1:0] sr [DEPTH];

            // Shift the word one stage along the chain each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < DEPTH; s++) sr[s] <= '0;
                end else begin
                    sr[0] <= d_i;
                    for (int s = 1; s < DEPTH; s++) sr[s] <= sr[s-1];
                end
            end

            assign q_o = sr[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cand_merge.sv
// Module: cand_merge
// Registers the incoming set (two stages). A set flagged invalid becomes
// all-empty. Then removes every candidate that a cross-source duplicate
// beats, and marks each remaining candidate that had a duplicate.
// Assumes: a duplicate means both valid, equal position, differing source.
module cand_merge
    import cand_pkg::*;
#(
    parameter int NUM_IN = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_vld_i,
    input  cand_t [NUM_IN-1:0]       cand_i,
    output logic                     set_vld_o,
    output cand_t [NUM_IN-1:0]       cand_o
);

    cand_t [NUM_IN-1:0] cap_q;
    logic               cap_vld_q;
    cand_t [NUM_IN-1:0] mrg_d;

    // Capture the input set; an invalid set is forced empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_vld_q <= 1'b0;
        end else begin
            cap_vld_q <= set_vld_i;
            cap_q     <= set_vld_i ? cand_i : '0;
        end
    end

    // For each entry, look for duplicates; drop it if one of them beats it.
    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            logic killed;
            logic partner;
            killed  = 1'b0;
            partner = 1'b0;
            for (int j = 0; j < NUM_IN; j++) begin
                if (j != i && cap_q[i].vld && cap_q[j].vld &&
                    cap_q[i].pos == cap_q[j].pos && cap_q[i].src != cap_q[j].src) begin
                    partner = 1'b1;
                    if (cap_q[j].rank > cap_q[i].rank ||
                        (cap_q[j].rank == cap_q[i].rank && j < i))
                        killed = 1'b1;
                end
            end
            mrg_d[i]       = cap_q[i];
            mrg_d[i].vld   = cap_q[i].vld & ~killed;
            mrg_d[i].spare = 1'b0;
            mrg_d[i].comb  = partner;
        end
    end

    // Register the merged set and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_o    <= '0;
            set_vld_o <= 1'b0;
        end else begin
            cand_o    <= mrg_d;
            set_vld_o <= cap_vld_q;
        end
    end

    // Check helper: any two surviving entries that are still duplicates.
    logic dup_left;
    always_comb begin
        dup_left = 1'b0;
        for (int i = 0; i < NUM_IN; i++)
            for (int j = i + 1; j < NUM_IN; j++)
                if (cand_o[i].vld && cand_o[j].vld &&
                    cand_o[i].pos == cand_o[j].pos && cand_o[i].src != cand_o[j].src)
                    dup_left = 1'b1;
    end

    a_r3_no_dup_survivors: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_left);

    a_r7_idle_capture_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld_q |-> (cap_q == '0));

endmodule

// File: rtl/top4_select.sv
// Module: top4_select
// Ranks all entries in one stage. An entry's place is the number of entries
// with a larger key {valid, rank, reversed index}; slot k takes the valid
// entry whose place is k. The result is registered.
// Assumes: index-based keys are unique, so at most one entry claims a slot.
module top4_select
    import cand_pkg::*;
#(
    parameter int NUM_IN  = 16,
    parameter int NUM_OUT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld_i,
    input  cand_t [NUM_IN-1:0]   cand_i,
    output logic                 set_vld_o,
    output cand_t [NUM_OUT-1:0]  slot_o
);

    localparam int IDX_W = $clog2(NUM_IN);
    localparam int KEY_W = 1 + RANK_W + IDX_W;

    logic [KEY_W-1:0]   key   [NUM_IN];
    logic [IDX_W:0]     place [NUM_IN];
    logic [NUM_IN-1:0]  hit   [NUM_OUT];
    cand_t [NUM_OUT-1:0] slot_d;

    // Build keys: lower index maps to a larger tie-break field.
    always_comb begin
        for (int i = 0; i < NUM_IN; i++)
            key[i] = {cand_i[i].vld, cand_i[i].rank, IDX_W'(NUM_IN - 1 - i)};
    end

    // Count how many entries outrank each entry.
    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            place[i] = '0;
            for (int j = 0; j < NUM_IN; j++)
                if (key[j] > key[i]) place[i] = place[i] + 1'b1;
        end
    end

    // Route each valid entry to the slot matching its place.
    always_comb begin
        for (int k = 0; k < NUM_OUT; k++) begin
            slot_d[k] = '0;
            for (int i = 0; i < NUM_IN; i++) begin
                hit[k][i] = cand_i[i].vld && (place[i] == (IDX_W+1)'(k));
                if (hit[k][i]) slot_d[k] = cand_i[i];
            end
        end
    end

    // Register the chosen slots and the set valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o    <= '0;
            set_vld_o <= 1'b0;
        end else begin
            slot_o    <= slot_d;
            set_vld_o <= set_vld_i;
        end
    end

    generate
        for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
            a_r4_one_claimant: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(hit[k]));
        end
        for (genvar k = 0; k + 1 < NUM_OUT; k++) begin : g_ord
            a_r5_filled_from_front: assert property (@(posedge clk) disable iff (!rst_n)
                slot_o[k+1].vld |-> slot_o[k].vld);
            a_r4_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
                slot_o[k+1].vld |-> (slot_o[k].rank >= slot_o[k+1].rank));
        end
    endgenerate

endmodule

// File: rtl/best_cand_sorter.sv
// Module: best_cand_sorter (top)
// Merges cross-source duplicates and outputs the best NUM_OUT candidates,
// best first. Takes one set per clock; results appear LATENCY clocks later.
// Assumes: LATENCY >= 3 (capture, merge and select stages are fixed).
module best_cand_sorter
    import cand_pkg::*;
#(
    parameter int NUM_IN  = 16,
    parameter int NUM_OUT = 4,
    parameter int LATENCY = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NUM_IN*CAND_W-1:0]    in_cands,
    output logic                        out_valid,
    output logic [NUM_OUT*CAND_W-1:0]   out_cands
);

    localparam int CORE_STAGES = 3;
    localparam int PAD         = LATENCY - CORE_STAGES;
    localparam int OUT_W       = NUM_OUT * CAND_W;

    cand_t [NUM_IN-1:0]  cand_in;
    cand_t [NUM_IN-1:0]  cand_mrg;
    cand_t [NUM_OUT-1:0] slot_sel;
    logic                vld_mrg;
    logic                vld_sel;
    logic [OUT_W:0]      pad_q;

    assign cand_in = in_cands;

    cand_merge #(.NUM_IN(NUM_IN)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld_i (in_valid),
        .cand_i    (cand_in),
        .set_vld_o (vld_mrg),
        .cand_o    (cand_mrg)
    );

    top4_select #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) select_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld_i (vld_mrg),
        .cand_i    (cand_mrg),
        .set_vld_o (vld_sel),
        .slot_o    (slot_sel)
    );

    pipe_delay #(.W(OUT_W + 1), .DEPTH(PAD)) pad_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({vld_sel, slot_sel}),
        .q_o   (pad_q)
    );

    assign out_valid = pad_q[OUT_W];
    assign out_cands = pad_q[OUT_W-1:0];

    a_r7_idle_output_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cands == '0));

    a_r6_spare_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel[0].spare == 1'b0) && (slot_sel[NUM_OUT-1].spare == 1'b0));

endmodule

// File: tb/best_cand_sorter_tb_top.sv
// Bench: fixed-seed random sets mixed with directed corner sets, each checked
// against a model that merges and ranks the candidates in its own way.
module best_cand_sorter_tb_top;

    localparam int NI  = 16;
    localparam int NO  = 4;
    localparam int LAT = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [NI*16-1:0] in_cands;
    logic            out_valid;
    logic [NO*16-1:0] out_cands;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 0;

    logic [NO*16-1:0] exp_c [16];
    logic             exp_v [16];
    string            exp_t [16];

    always #4 clk = ~clk;

    best_cand_sorter #(.NUM_IN(NI), .NUM_OUT(NO), .LATENCY(LAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_cands  (in_cands),
        .out_valid (out_valid),
        .out_cands (out_cands)
    );

    function automatic logic [15:0] mk(input logic v, input logic [2:0] r,
                                       input logic [7:0] p, input logic [1:0] s,
                                       input logic [1:0] sp);
        return {v, r, p, s, sp};
    endfunction

    // Model: decide survivors per R2/R3, then pick the best NO by repeated max.
    function automatic logic [NO*16-1:0] model(input logic v, input logic [NI*16-1:0] c);
        logic keep [NI];
        logic flag [NI];
        logic used [NI];
        logic [NO*16-1:0] res = '0;
        if (!v) return '0;
        for (int i = 0; i < NI; i++) begin
            logic [15:0] a = c[i*16 +: 16];
            keep[i] = a[15];
            flag[i] = 1'b0;
            used[i] = 1'b0;
            for (int j = 0; j < NI; j++) begin
                logic [15:0] b = c[j*16 +: 16];
                if (j != i && a[15] && b[15] && a[11:4] == b[11:4] && a[3:2] != b[3:2]) begin
                    flag[i] = 1'b1;
                    if (b[14:12] > a[14:12] || (b[14:12] == a[14:12] && j < i)) keep[i] = 1'b0;
                end
            end
        end
        for (int k = 0; k < NO; k++) begin
            int best = -1;
            for (int i = 0; i < NI; i++)
                if (keep[i] && !used[i] &&
                    (best < 0 || c[i*16+12 +: 3] > c[best*16+12 +: 3]))
                    best = i;
            if (best >= 0) begin
                used[best] = 1'b1;
                res[k*16 +: 16] = {1'b1, c[best*16+2 +: 13], 1'b0, flag[best]};
            end
        end
        return res;
    endfunction

    task automatic check_out();
        int idx;
        if (cyc < LAT) return;
        idx = (cyc - LAT) % 16;
        checks++;
        if (out_valid !== exp_v[idx]) begin
            failures++;
            $display("FAIL %s out_valid got %b exp %b", exp_t[idx], out_valid, exp_v[idx]);
        end
        checks++;
        if (out_cands !== exp_c[idx]) begin
            failures++;
            $display("FAIL %s out_cands got %h exp %h", exp_t[idx], out_cands, exp_c[idx]);
        end
    endtask

    // One clock: check the result due now, then present a new set (R8 timing).
    task automatic step(input logic v, input logic [NI*16-1:0] c, input string tag);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_cands = c;
        exp_v[cyc % 16] = v;
        exp_c[cyc % 16] = model(v, c);
        exp_t[cyc % 16] = tag;
        cyc++;
    endtask

    function automatic logic [NI*16-1:0] rand_set();
        logic [NI*16-1:0] c;
        for (int i = 0; i < NI; i++)
            c[i*16 +: 16] = mk(($urandom % 8) != 0, 3'($urandom), 8'($urandom % 4) + 8'h30,
                               2'($urandom % 3), 2'($urandom));
        return c;
    endfunction

    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            cnt++;
            if (cnt > 20000 && !done) begin
                done = 1;
                failures++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [NI*16-1:0] c;
        void'($urandom(32'd7741));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_cands = '1;
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_cands !== '0) begin
            failures++;
            $display("FAIL R1 during reset got %b/%h exp 0/0", out_valid, out_cands);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_cands !== '0) begin
            failures++;
            $display("FAIL R1 after release got %b/%h exp 0/0", out_valid, out_cands);
        end

        // R5: valid set with no valid candidates gives empty slots.
        step(1'b1, '0, "R5 empty set");

        // R2,R3: three-source group at one position plus a lone entry.
        c = '0;
        c[0*16 +: 16]  = mk(1, 3, 8'h21, 0, 0);
        c[5*16 +: 16]  = mk(1, 6, 8'h21, 1, 0);
        c[9*16 +: 16]  = mk(1, 2, 8'h21, 2, 0);
        c[12*16 +: 16] = mk(1, 4, 8'h40, 0, 0);
        step(1'b1, c, "R3 three-way merge");

        // R4: equal ranks resolved by index; fifth candidate drops out.
        c = '0;
        c[2*16 +: 16]  = mk(1, 5, 8'h01, 1, 0);
        c[3*16 +: 16]  = mk(1, 7, 8'h02, 1, 0);
        c[7*16 +: 16]  = mk(1, 5, 8'h03, 1, 0);
        c[11*16 +: 16] = mk(1, 5, 8'h04, 1, 0);
        c[14*16 +: 16] = mk(1, 5, 8'h05, 1, 0);
        step(1'b1, c, "R4 tie order");

        // R2: same source and same position are not duplicates.
        c = '0;
        c[1*16 +: 16] = mk(1, 2, 8'h55, 1, 0);
        c[4*16 +: 16] = mk(1, 6, 8'h55, 1, 0);
        step(1'b1, c, "R2 same source kept");

        // R3: equal-rank duplicate, lower index survives.
        c = '0;
        c[3*16 +: 16] = mk(1, 4, 8'h77, 2, 0);
        c[6*16 +: 16] = mk(1, 4, 8'h77, 0, 0);
        step(1'b1, c, "R3 equal rank merge");

        // R7: invalid set with real-looking candidates.
        step(1'b0, rand_set(), "R7 invalid set");

        // R6: spare input bits set everywhere.
        c = '0;
        c[0*16 +: 16]  = mk(1, 1, 8'h10, 0, 2'b11);
        c[8*16 +: 16]  = mk(1, 3, 8'h10, 2, 2'b11);
        c[15*16 +: 16] = mk(1, 7, 8'hF0, 1, 2'b11);
        step(1'b1, c, "R6 spare ignored");

        // R8: back-to-back random sets, with occasional idle sets.
        for (int n = 0; n < 80; n++)
            step(($urandom % 6) != 0, rand_set(), "R8 stream R3 R4");

        for (int n = 0; n < LAT + 1; n++)
            step(1'b0, '0, "R7 flush");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule